// File: doc/BRIEF.md
# Byte-Stream Command Processor with GPIO

This block interprets a stream of command bytes that a host places into an input FIFO. Each command starts with a one-byte opcode, and some opcodes carry parameter bytes after them. The commands program the output values and drive enables of two 8-bit general-purpose ports, read back the low port's pin levels, switch internal loopback, load a 16-bit clock divisor and clear a prescaler flag. They can also push payload bytes into an attached shift engine, which does the bit-level serial work. Any byte the processor has to return, such as a pin read, an error report or a byte the shift engine captured, goes out on a return byte stream.

The processor takes one input byte per accepted handshake and holds its decode state across any number of idle cycles. A data command is followed by a two-byte length and then length+1 payload bytes. While that payload is outstanding, the bytes pass straight through to the shift engine and are never read as opcodes. In the capturing variant, the processor waits after each payload byte for the engine's captured byte, forwards it to the return stream, and only then accepts the next payload byte.

Top module: `hostcmd_engine`

## Requirements
- R1: After reset, `lo_oe`, `hi_oe`, `lo_out`, `hi_out` and `divisor` are all zero, `loopback` is 0, `div5_en` is 1 and `out_valid` is 0.
- R2: Opcode 0x80 is followed by a value byte and then a direction byte. Once both are taken, `lo_out` equals the value and `lo_oe` equals the direction, where bit=1 means that pin drives.
- R3: Opcode 0x82 takes the same value-then-direction pair and applies it to `hi_out`/`hi_oe`.
- R4: Opcode 0x81 returns exactly one byte, equal to `lo_pin_in` as sampled in the cycle the opcode is accepted.
- R5: Opcode 0x84 sets `loopback` to 1 and opcode 0x85 clears it. Neither returns a byte.
- R6: Opcode 0x86 is followed by two bytes, and `divisor` becomes {second byte, first byte}. `divisor` changes at no other time.
- R7: Opcode 0x8A clears `div5_en`. Opcodes 0x8D and 0x97 are accepted with no visible state change. None of the three returns a byte.
- R8: Any other opcode returns two bytes: 0xFA first, then the offending opcode.
- R9: Opcode 0x10 is followed by the length low byte, the length high byte and length+1 payload bytes. Each payload byte is handed to the shift engine in order with `sh_tx_capture`=0, and nothing is returned.
- R10: Opcode 0x34 has the same format but uses `sh_tx_capture`=1. Each byte the engine captures is forwarded to the return stream before the next payload byte is accepted, so exactly one byte comes back per byte sent.
- R11: Payload bytes are never decoded as opcodes, even when they equal opcode values. Also, the input is never accepted in a cycle in which a return byte is offered.
- R12: Idle cycles on the input at any point inside a command, including during a payload, do not change the outcome of that command.
- R13: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Command byte from the host FIFO |
| in_valid | input | 1 | Host FIFO holds a byte |
| in_ready | output | 1 | Byte is taken when in_valid and in_ready are both 1 |
| out_data | output | 8 | Return byte |
| out_valid | output | 1 | Return byte is offered |
| out_ready | input | 1 | Return FIFO accepts the byte |
| lo_pin_in | input | 8 | Actual levels of the low port pins |
| lo_out | output | 8 | Low port output values |
| lo_oe | output | 8 | Low port drive enables (1 = output) |
| hi_out | output | 8 | High port output values |
| hi_oe | output | 8 | High port drive enables (1 = output) |
| loopback | output | 1 | Internal loopback enable for the shift engine |
| divisor | output | 16 | Serial clock divisor |
| div5_en | output | 1 | Divide-by-5 prescaler enable |
| sh_tx_data | output | 8 | Payload byte to the shift engine |
| sh_tx_valid | output | 1 | Payload byte offered |
| sh_tx_capture | output | 1 | The engine must capture one byte for this payload byte |
| sh_tx_ready | input | 1 | Shift engine takes the payload byte |
| sh_rx_data | input | 8 | Byte captured by the shift engine |
| sh_rx_valid | input | 1 | Captured byte offered |
| sh_rx_ready | output | 1 | Captured byte taken |

## Verification
The hold-stable assertion on the return stream assumes that the shift engine keeps `sh_rx_valid` and `sh_rx_data` steady until the captured byte is taken. It also assumes that the engine offers a captured byte only after taking a payload byte flagged for capture. The bench's engine model keeps both rules: it produces one captured byte per flagged payload byte and holds it until the handshake, while randomly throttling `sh_tx_ready`. Host bytes only change after a handshake or while `in_valid` is 0, and the return side is throttled at random, plus one directed long stall.

// File: rtl/cmd_pkg.sv
// Shared constants and types for the byte-stream command processor.
// Assumes 8-bit command bytes; opcode values are fixed by the host protocol.
package cmd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_OP,     // waiting for an opcode
        ST_PARAM,  // collecting two parameter bytes
        ST_RESP,   // emitting one or two response bytes
        ST_PAY,    // forwarding payload bytes to the shift engine
        ST_RX      // waiting to forward a captured byte
    } cmd_st_t;

    localparam logic [7:0] OP_SET_LO   = 8'h80;
    localparam logic [7:0] OP_RD_LO    = 8'h81;
    localparam logic [7:0] OP_SET_HI   = 8'h82;
    localparam logic [7:0] OP_LB_ON    = 8'h84;
    localparam logic [7:0] OP_LB_OFF   = 8'h85;
    localparam logic [7:0] OP_DIV      = 8'h86;
    localparam logic [7:0] OP_NO_DIV5  = 8'h8A;
    localparam logic [7:0] OP_NO_3PH   = 8'h8D;
    localparam logic [7:0] OP_NO_ADAPT = 8'h97;
    localparam logic [7:0] OP_TX       = 8'h10;
    localparam logic [7:0] OP_TXRX     = 8'h34;
    localparam logic [7:0] RSP_BAD     = 8'hFA;
endpackage

// File: rtl/cmd_port_reg.sv
// Output value and drive-enable register pair for one GPIO port.
// Assumes wr is a single-cycle strobe; both fields load together.
module cmd_port_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] val,
    input  logic [W-1:0] dir,
    output logic [W-1:0] q_val,
    output logic [W-1:0] q_dir
);
    // Hold the port setting; reset leaves every pin an input driving 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_val <= '0;
            q_dir <= '0;
        end else if (wr) begin
            q_val <= val;
            q_dir <= dir;
        end
    end

    // R2 R3
    port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q_val == $past(val)) && (q_dir == $past(dir)));

    // R2 R3
    port_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q_val) && $stable(q_dir));
endmodule

// File: rtl/cmd_xfer_ctr.sv
// Remaining-payload counter for a data command.
// Assumes load and dec are never asserted together; last means this is the final byte.
module cmd_xfer_ctr #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [LW-1:0] cnt;

    // Count down the payload bytes still owed after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (dec)   cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    // R9
    len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R9 R10
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/hostcmd_engine.sv
// Byte-stream command processor: decodes opcodes from the host FIFO, programs
// two GPIO ports, loopback, divisor and prescaler, and drives the shift engine.
// Assumes the shift engine holds sh_rx_* until taken, and offers a captured byte
// only after it has taken a payload byte flagged for capture.
module hostcmd_engine #(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    input  logic [7:0]  lo_pin_in,
    output logic [7:0]  lo_out,
    output logic [7:0]  lo_oe,
    output logic [7:0]  hi_out,
    output logic [7:0]  hi_oe,
    output logic        loopback,
    output logic [15:0] divisor,
    output logic        div5_en,
    output logic [7:0]  sh_tx_data,
    output logic        sh_tx_valid,
    output logic        sh_tx_capture,
    input  logic        sh_tx_ready,
    input  logic [7:0]  sh_rx_data,
    input  logic        sh_rx_valid,
    output logic        sh_rx_ready
);
    import cmd_pkg::*;

    localparam int PAIR_W = 2 * BYTE_W;

    cmd_st_t            st;
    logic [BYTE_W-1:0]  op;
    logic               pidx;
    logic [BYTE_W-1:0]  p0;
    logic [BYTE_W-1:0]  resp0, resp1;
    logic               rtwo, ridx;
    logic               cap;
    logic               in_fire, rx_fire, pair_done, last;
    logic               lo_wr, hi_wr, len_load, len_dec;
    logic [PAIR_W-1:0]  pair;

    // Handshake and pass-through steering for each state.
    always_comb begin
        in_ready    = (st == ST_OP) || (st == ST_PARAM) || ((st == ST_PAY) && sh_tx_ready);
        in_fire     = in_valid && in_ready;
        sh_tx_valid = (st == ST_PAY) && in_valid;
        sh_tx_data  = in_data;
        sh_tx_capture = cap;
        sh_rx_ready = (st == ST_RX) && out_ready;
        rx_fire     = sh_rx_valid && sh_rx_ready;
        out_valid   = (st == ST_RESP) || ((st == ST_RX) && sh_rx_valid);
        out_data    = (st == ST_RX) ? sh_rx_data : (ridx ? resp1 : resp0);
    end

    // Strobes for the register banks and the payload counter.
    always_comb begin
        pair_done = (st == ST_PARAM) && in_fire && pidx;
        pair      = {in_data, p0};
        lo_wr     = pair_done && (op == OP_SET_LO);
        hi_wr     = pair_done && (op == OP_SET_HI);
        len_load  = pair_done && ((op == OP_TX) || (op == OP_TXRX));
        len_dec   = ((st == ST_PAY) && in_fire && !cap && !last) ||
                    ((st == ST_RX) && rx_fire && !last);
    end

    // Command sequencer: opcode decode, parameter collection, responses, payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OP;
            op       <= '0;
            pidx     <= 1'b0;
            p0       <= '0;
            resp0    <= '0;
            resp1    <= '0;
            rtwo     <= 1'b0;
            ridx     <= 1'b0;
            cap      <= 1'b0;
            loopback <= 1'b0;
            divisor  <= '0;
            div5_en  <= 1'b1;
        end else begin
            case (st)
                ST_OP: if (in_fire) begin
                    op <= in_data;
                    case (in_data)
                        OP_SET_LO, OP_SET_HI, OP_DIV, OP_TX, OP_TXRX: begin
                            pidx <= 1'b0;
                            st   <= ST_PARAM;
                        end
                        OP_RD_LO: begin
                            resp0 <= lo_pin_in;
                            rtwo  <= 1'b0;
                            ridx  <= 1'b0;
                            st    <= ST_RESP;
                        end
                        OP_LB_ON:   loopback <= 1'b1;
                        OP_LB_OFF:  loopback <= 1'b0;
                        OP_NO_DIV5: div5_en  <= 1'b0;
                        OP_NO_3PH, OP_NO_ADAPT: ;
                        default: begin
                            resp0 <= RSP_BAD;
                            resp1 <= in_data;
                            rtwo  <= 1'b1;
                            ridx  <= 1'b0;
                            st    <= ST_RESP;
                        end
                    endcase
                end
                ST_PARAM: if (in_fire) begin
                    if (!pidx) begin
                        p0   <= in_data;
                        pidx <= 1'b1;
                    end else begin
                        pidx <= 1'b0;
                        case (op)
                            OP_DIV:  begin divisor <= pair; st <= ST_OP; end
                            OP_TX:   begin cap <= 1'b0; st <= ST_PAY; end
                            OP_TXRX: begin cap <= 1'b1; st <= ST_PAY; end
                            default: st <= ST_OP;
                        endcase
                    end
                end
                ST_RESP: if (out_ready) begin
                    if (rtwo && !ridx) ridx <= 1'b1;
                    else               st   <= ST_OP;
                end
                ST_PAY: if (in_fire) begin
                    if (cap)       st <= ST_RX;
                    else if (last) st <= ST_OP;
                end
                ST_RX: if (rx_fire) begin
                    st <= last ? ST_OP : ST_PAY;
                end
                default: st <= ST_OP;
            endcase
        end
    end

    cmd_port_reg #(.W(BYTE_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .wr(lo_wr), .val(p0), .dir(in_data),
        .q_val(lo_out), .q_dir(lo_oe)
    );

    cmd_port_reg #(.W(BYTE_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .wr(hi_wr), .val(p0), .dir(in_data),
        .q_val(hi_out), .q_dir(hi_oe)
    );

    cmd_xfer_ctr #(.LW(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .load(len_load), .load_val(LEN_W'(pair)),
        .dec(len_dec), .last(last)
    );

    // R13
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R6
    div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divisor) |-> $past(pair_done && (op == OP_DIV)));

    // R11
    pay_no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_valid && sh_tx_ready && !cap && !last) |=> (st == ST_PAY));

    // R10
    rx_only_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fire |-> cap);
endmodule

// File: tb/sim_hostcmd_engine.sv
module sim_hostcmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  lo_pin_in = 8'h00;
    logic [7:0]  lo_out, lo_oe, hi_out, hi_oe;
    logic        loopback, div5_en;
    logic [15:0] divisor;
    logic [7:0]  sh_tx_data;
    logic        sh_tx_valid, sh_tx_capture;
    logic        sh_tx_ready = 1'b0;
    logic [7:0]  sh_rx_data = 8'h00;
    logic        sh_rx_valid = 1'b0;
    logic        sh_rx_ready;

    always #10 clk = ~clk;

    hostcmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .lo_pin_in(lo_pin_in), .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
        .loopback(loopback), .divisor(divisor), .div5_en(div5_en),
        .sh_tx_data(sh_tx_data), .sh_tx_valid(sh_tx_valid), .sh_tx_capture(sh_tx_capture),
        .sh_tx_ready(sh_tx_ready), .sh_rx_data(sh_rx_data), .sh_rx_valid(sh_rx_valid),
        .sh_rx_ready(sh_rx_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_tag = "R1";
    logic [7:0] exp_out[$];
    logic [8:0] exp_tx[$];
    logic [7:0] m_lo_out = 0, m_lo_oe = 0, m_hi_out = 0, m_hi_oe = 0;
    logic [15:0] m_div = 0;
    logic m_loop = 0, m_div5 = 1;
    logic hold_force = 0;
    logic hold_v = 0;
    logic [7:0] hold_d = 0;
    logic rx_pend = 0, rx_taken = 0;
    logic [7:0] rx_pend_d = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_known(input logic [7:0] b);
        return b inside {8'h80, 8'h81, 8'h82, 8'h84, 8'h85, 8'h86, 8'h8A, 8'h8D, 8'h97, 8'h10, 8'h34};
    endfunction

    function automatic logic [7:0] cap_of(input logic [7:0] b);
        return b ^ 8'hA5;
    endfunction

    // Shift-engine and return-side model, driven on the falling edge.
    always @(negedge clk) begin
        if (rx_taken) begin
            sh_rx_valid = 1'b0;
            rx_taken = 1'b0;
        end
        if (!sh_rx_valid && rx_pend) begin
            sh_rx_valid = 1'b1;
            sh_rx_data = rx_pend_d;
            rx_pend = 1'b0;
        end
        sh_tx_ready = ($urandom % 4) != 0;
        if (!hold_force) out_ready = ($urandom % 4) != 0;
    end

    // Monitor: decides which handshakes fire at the coming rising edge.
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (hold_v)  // R13
                chk(out_valid && out_data == hold_d, "R13", {out_valid, out_data}, {1'b1, hold_d});
            hold_v = out_valid && !out_ready;
            hold_d = out_data;
            if (out_valid && out_ready) begin
                if (exp_out.size() == 0)
                    chk(0, {cur_tag, " unexpected out"}, out_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_out.pop_front();
                    chk(out_data == e, cur_tag, out_data, e);
                end
            end
            if (sh_tx_valid && sh_tx_ready) begin
                if (exp_tx.size() == 0)
                    chk(0, {cur_tag, " unexpected tx"}, {sh_tx_capture, sh_tx_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_tx.pop_front();
                    chk({sh_tx_capture, sh_tx_data} == e, cur_tag, {sh_tx_capture, sh_tx_data}, e);
                end
                if (sh_tx_capture) begin
                    rx_pend = 1'b1;
                    rx_pend_d = cap_of(sh_tx_data);
                end
            end
            if (sh_rx_valid && sh_rx_ready) rx_taken = 1'b1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_data = b;
        in_valid = 1'b1;
        forever begin
            #2;
            if (in_ready) begin
                @(posedge clk);
                #1;
                in_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_state(input string tag);
        chk({lo_out, lo_oe, hi_out, hi_oe, divisor} == {m_lo_out, m_lo_oe, m_hi_out, m_hi_oe, m_div},
            {tag, " regs"}, {lo_out, lo_oe, hi_out, hi_oe, divisor},
            {m_lo_out, m_lo_oe, m_hi_out, m_hi_oe, m_div});
        chk({loopback, div5_en} == {m_loop, m_div5}, {tag, " flags"},
            {loopback, div5_en}, {m_loop, m_div5});
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_out.size() != 0 || exp_tx.size() != 0) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(exp_out.size() == 0 && exp_tx.size() == 0, {cur_tag, " drained"},
            exp_out.size() + exp_tx.size(), 0);
        check_state(cur_tag);
    endtask

    task automatic cmd_set(input bit hi, input logic [7:0] v, input logic [7:0] d, input int gap);
        cur_tag = hi ? "R3" : "R2";
        put(hi ? 8'h82 : 8'h80, $urandom % 3);
        put(v, gap);
        put(d, gap);
        if (hi) begin m_hi_out = v; m_hi_oe = d; end
        else    begin m_lo_out = v; m_lo_oe = d; end
        drain();
    endtask

    task automatic cmd_read(input logic [7:0] pins);
        cur_tag = "R4";
        lo_pin_in = pins;
        exp_out.push_back(pins);
        put(8'h81, $urandom % 3);
        drain();
    endtask

    task automatic cmd_single(input logic [7:0] op, input string tag);
        cur_tag = tag;
        put(op, $urandom % 3);
        if (op == 8'h84) m_loop = 1'b1;
        if (op == 8'h85) m_loop = 1'b0;
        if (op == 8'h8A) m_div5 = 1'b0;
        drain();
    endtask

    task automatic cmd_div(input logic [15:0] dv, input int gap);
        cur_tag = "R6";
        put(8'h86, $urandom % 3);
        put(dv[7:0], gap);
        put(dv[15:8], gap);
        m_div = dv;
        drain();
    endtask

    task automatic cmd_bad(input logic [7:0] op);
        cur_tag = "R8";
        exp_out.push_back(8'hFA);
        exp_out.push_back(op);
        put(op, $urandom % 3);
        drain();
    endtask

    task automatic cmd_xfer(input bit cap, input logic [15:0] len, input int gapmax, input bit opcodes);
        cur_tag = cap ? "R10" : "R9";
        put(cap ? 8'h34 : 8'h10, $urandom % 3);
        put(len[7:0], $urandom % 3);
        put(len[15:8], $urandom % 3);
        for (int i = 0; i <= int'(len); i++) begin
            logic [7:0] b;
            b = opcodes ? ((i % 2 == 0) ? 8'hAB : 8'h81) : 8'($urandom);
            exp_tx.push_back({cap, b});
            if (cap) exp_out.push_back(cap_of(b));
            put(b, (gapmax > 0) ? int'($urandom % gapmax) : 0);
        end
        drain();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held and just after release
        chk({lo_out, lo_oe, hi_out, hi_oe, divisor} == 48'h0, "R1 regs",
            {lo_out, lo_oe, hi_out, hi_oe, divisor}, 0);
        chk({loopback, div5_en, out_valid} == 3'b010, "R1 flags",
            {loopback, div5_en, out_valid}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle", {out_valid, in_ready}, 2'b01);
        check_state("R1");

        cmd_bad(8'hAB);                         // R8
        cmd_set(0, 8'h5A, 8'hF0, 0);            // R2
        cmd_set(1, 8'hC3, 8'h0F, 1);            // R3
        cmd_read(8'h96);                        // R4
        cmd_single(8'h84, "R5");                // R5 on
        cmd_single(8'h85, "R5");                // R5 off
        cmd_single(8'h84, "R5");
        cmd_div(16'h05DB, 0);                   // R6
        cmd_single(8'h8D, "R7");                // R7 silent
        cmd_single(8'h97, "R7");
        cmd_single(8'h8A, "R7");
        cmd_xfer(0, 16'd0, 0, 1);               // R11: single opcode-looking payload
        cmd_xfer(0, 16'd5, 3, 1);               // R11 R9
        cmd_xfer(1, 16'd3, 2, 1);               // R11 R10
        cmd_xfer(1, 16'd0, 0, 0);               // R10 length zero
        // R12: long idle gaps in the middle of commands
        cmd_set(0, 8'h3C, 8'hA5, 25);
        cmd_div(16'hBEEF, 20);
        cmd_xfer(1, 16'd2, 30, 0);
        cmd_bad(8'h00);
        cmd_bad(8'hFF);
        cmd_read(8'h00);
        // R13: return side blocked for a stretch
        cur_tag = "R13";
        hold_force = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        exp_out.push_back(8'hFA);
        exp_out.push_back(8'h83);
        put(8'h83, 0);
        repeat (8) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'hFA, "R13 held", {out_valid, out_data}, 9'h1FA);
        hold_force = 1'b0;
        cur_tag = "R8";
        drain();

        // Random command mix
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom % 9;
            case (sel)
                0: cmd_set(0, 8'($urandom), 8'($urandom), $urandom % 4);
                1: cmd_set(1, 8'($urandom), 8'($urandom), $urandom % 4);
                2: cmd_read(8'($urandom));
                3: cmd_single(($urandom % 2) ? 8'h84 : 8'h85, "R5");
                4: cmd_div(16'($urandom), $urandom % 4);
                5: cmd_xfer(0, 16'($urandom % 6), 3, $urandom % 2);
                6: cmd_xfer(1, 16'($urandom % 6), 3, $urandom % 2);
                7: begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    while (is_known(b)) b = 8'($urandom);
                    cmd_bad(b);
                end
                default: cmd_single(($urandom % 2) ? 8'h8D : 8'h97, "R7");
            endcase
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule